// File: doc/BRIEF.md
# Level-Sensitive Interrupt Aggregator

This block collects a wide vector of level-sensitive interrupt inputs and folds them into a single interrupt request towards a processor. The inputs are split into banks of 32. Each bank keeps a mask word and shows a masked pending word. Software never writes a mask word directly. It sets mask bits through one alias address and clears them through another, so it can change one source without a read-modify-write.

The request line is latched. Once it fires, it stays high until software writes the acknowledge bit in the control register. If any unmasked source is still pending after that, the request fires again on the following cycle. This is what makes level-sensitive handling work.

A small system section provides a revision code, an autoidle configuration bit and a software-started reset. The software reset restores the masks and configuration over a fixed number of cycles, and a status flag tells software when it has finished. The bus is a simple single-cycle register port. Writes take effect on the clock edge, and reads are combinational while the read strobe is high.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: After hardware reset every mask bit is 1, `irq_out` is 0, `idle_auto_en` is 0 and the reset-done flag (bit 0 at 0x014) reads 1; a high source therefore shows nothing in any pending word.
- R2: A write to 0x088 + 0x20*k clears the mask bit of source 32*k+n for every 1 in data bit n; 0 bits leave their mask bits as they were.
- R3: A write to 0x08C + 0x20*k sets the mask bit of source 32*k+n for every 1 in data bit n; 0 bits leave their mask bits as they were.
- R4: A read of 0x098 + 0x20*k returns, in bit n, the input of source 32*k+n ANDed with the inverse of its mask bit.
- R5: When any unmasked source is high and no request is outstanding, `irq_out` goes to 1 on the next clock edge and then stays at 1, whatever the sources do, until it is acknowledged.
- R6: A write to 0x048 with data bit 0 equal to 1 drives `irq_out` to 0 on that clock edge; a write to 0x048 with bit 0 equal to 0 has no effect.
- R7: If an unmasked source is still high after an acknowledge, `irq_out` returns to 1 one clock edge after it dropped.
- R8: A write to 0x010 with bit 1 set starts a soft reset. The done flag reads 0 for SRST_CYC cycles and then 1. `idle_auto_en` is cleared at once, every mask bit becomes 1, and `irq_out` falls to 0.
- R9: A write to 0x010 with bit 1 clear loads data bit 0 into the autoidle bit; that bit reads back in bit 0 of 0x010 and drives `idle_auto_en`.
- R10: A read of 0x000 returns REV_MAJOR in bits 7:4 and REV_MINOR in bits 3:0, with all other bits 0.
- R11: Reads of unmapped addresses and of the write-only addresses (0x048 and the mask alias addresses) return 0, and `bus_rdata` is 0 whenever `bus_rd` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, gates the read data |
| bus_addr | input | 12 | Byte address of the register, word aligned |
| bus_wdata | input | BANK_W (32) | Write data |
| bus_rdata | output | BANK_W (32) | Combinational read data |
| irq_src | input | NUM_SRC (96) | Level-sensitive source inputs |
| irq_out | output | 1 | Latched interrupt request |
| idle_auto_en | output | 1 | Autoidle configuration bit |

## Verification
The bench builds the block with its default parameters: NUM_SRC = 96, BANK_W = 32, SRST_CYC = 4 and revision 2.1. Three banks bring the top bank's alias addresses (0x0C8, 0x0CC, 0x0D8) and its highest source, number 95, within reach. The short soft-reset window allows the done flag to be sampled on every cycle of the sequence. The 32-bit banks expose both edge bits, 0 and 31, of a mask word to the set and clear aliases.

// File: rtl/lvlirq_pkg.sv
package lvlirq_pkg;
  localparam int ADDR_W = 12;
  typedef logic [ADDR_W-1:0] reg_addr_t;

  localparam reg_addr_t OFS_REV   = 12'h000;
  localparam reg_addr_t OFS_CFG   = 12'h010;
  localparam reg_addr_t OFS_STAT  = 12'h014;
  localparam reg_addr_t OFS_CTRL  = 12'h048;
  localparam reg_addr_t OFS_MCLR  = 12'h088;
  localparam reg_addr_t OFS_MSET  = 12'h08C;
  localparam reg_addr_t OFS_PEND  = 12'h098;
  localparam int        BANK_STEP = 32'h20;

  // address of a per-bank register: base plus bank index times stride
  function automatic reg_addr_t bank_addr(input reg_addr_t base, input int unsigned k);
    return base + reg_addr_t'(k * BANK_STEP);
  endfunction

  // revision byte: major in the upper nibble, minor in the lower
  function automatic logic [7:0] rev_byte(input int unsigned major, input int unsigned minor);
    return {4'(major), 4'(minor)};
  endfunction
endpackage

// File: rtl/lvlirq_mask_bank.sv
module lvlirq_mask_bank
  import lvlirq_pkg::*;
#(
  parameter int BANK_W = 32,
  parameter int IDX    = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              srst_busy,
  input  logic              wr_en,
  input  reg_addr_t         addr,
  input  logic [BANK_W-1:0] wdata,
  input  logic [BANK_W-1:0] src,
  output logic [BANK_W-1:0] mask_q,
  output logic [BANK_W-1:0] pend,
  output logic [BANK_W-1:0] rd_val
);
  localparam reg_addr_t A_CLR  = bank_addr(OFS_MCLR, IDX);
  localparam reg_addr_t A_SET  = bank_addr(OFS_MSET, IDX);
  localparam reg_addr_t A_PEND = bank_addr(OFS_PEND, IDX);

  wire hit_set = wr_en && (addr == A_SET);
  wire hit_clr = wr_en && (addr == A_CLR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          mask_q <= '1;
    else if (srst_busy)  mask_q <= '1;
    else if (hit_set)    mask_q <= mask_q | wdata;
    else if (hit_clr)    mask_q <= mask_q & ~wdata;
  end

  assign pend   = src & ~mask_q;
  assign rd_val = (addr == A_PEND) ? pend : '0;
endmodule

// File: rtl/lvlirq_sysctl.sv
module lvlirq_sysctl
  import lvlirq_pkg::*;
#(
  parameter int SRST_CYC = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_en,
  input  reg_addr_t addr,
  input  logic [1:0] wdata,
  output logic      autoidle_q,
  output logic      srst_busy
);
  localparam int CNT_W = $clog2(SRST_CYC + 1);
  logic [CNT_W-1:0] cnt_q;

  wire cfg_wr = wr_en && (addr == OFS_CFG) && !srst_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      autoidle_q <= 1'b0;
      srst_busy  <= 1'b0;
      cnt_q      <= '0;
    end else if (srst_busy) begin
      cnt_q     <= cnt_q - CNT_W'(1);
      srst_busy <= (cnt_q != CNT_W'(1));
    end else if (cfg_wr) begin
      if (wdata[1]) begin
        srst_busy  <= 1'b1;
        cnt_q      <= CNT_W'(SRST_CYC);
        autoidle_q <= 1'b0;
      end else begin
        autoidle_q <= wdata[0];
      end
    end
  end
endmodule

// File: rtl/lvlirq_gate.sv
module lvlirq_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic srst_busy,
  input  logic ack_evt,
  input  logic pend_any,
  output logic irq_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   irq_q <= 1'b0;
    else if (srst_busy || ack_evt) irq_q <= 1'b0;
    else if (!irq_q && pend_any)  irq_q <= 1'b1;
  end
endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl
  import lvlirq_pkg::*;
#(
  parameter int NUM_SRC   = 96,
  parameter int BANK_W    = 32,
  parameter int SRST_CYC  = 4,
  parameter int REV_MAJOR = 2,
  parameter int REV_MINOR = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [BANK_W-1:0]  bus_wdata,
  output logic [BANK_W-1:0]  bus_rdata,
  input  logic [NUM_SRC-1:0] irq_src,
  output logic               irq_out,
  output logic               idle_auto_en
);
  localparam int NUM_BANK = NUM_SRC / BANK_W;

  logic [BANK_W-1:0]  mask_arr [NUM_BANK];
  logic [BANK_W-1:0]  pend_arr [NUM_BANK];
  logic [BANK_W-1:0]  rdv_arr  [NUM_BANK];
  logic [NUM_SRC-1:0] mask_flat;
  logic               pend_any;
  logic               srst_busy;
  logic               ack_evt;

  assign ack_evt = bus_wr && (bus_addr == OFS_CTRL) && bus_wdata[0];

  for (genvar k = 0; k < NUM_BANK; k++) begin : g_bank
    lvlirq_mask_bank #(.BANK_W(BANK_W), .IDX(k)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .srst_busy (srst_busy),
      .wr_en     (bus_wr),
      .addr      (bus_addr),
      .wdata     (bus_wdata),
      .src       (irq_src[k*BANK_W +: BANK_W]),
      .mask_q    (mask_arr[k]),
      .pend      (pend_arr[k]),
      .rd_val    (rdv_arr[k])
    );
    assign mask_flat[k*BANK_W +: BANK_W] = mask_arr[k];
  end

  always_comb begin
    pend_any = 1'b0;
    for (int k = 0; k < NUM_BANK; k++) pend_any = pend_any | (|pend_arr[k]);
  end

  lvlirq_sysctl #(.SRST_CYC(SRST_CYC)) u_sys (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (bus_wr),
    .addr       (bus_addr),
    .wdata      (bus_wdata[1:0]),
    .autoidle_q (idle_auto_en),
    .srst_busy  (srst_busy)
  );

  lvlirq_gate u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .srst_busy (srst_busy),
    .ack_evt   (ack_evt),
    .pend_any  (pend_any),
    .irq_q     (irq_out)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      unique case (bus_addr)
        OFS_REV:  bus_rdata[7:0] = rev_byte(REV_MAJOR, REV_MINOR);
        OFS_CFG:  bus_rdata[0]   = idle_auto_en;
        OFS_STAT: bus_rdata[0]   = !srst_busy;
        default:  bus_rdata      = '0;
      endcase
      for (int k = 0; k < NUM_BANK; k++) bus_rdata = bus_rdata | rdv_arr[k];
    end
  end
endmodule

// File: rtl/lvlirq_checker.sv
module lvlirq_checker #(
  parameter int NUM_SRC   = 96,
  parameter int DATA_W    = 32,
  parameter int REV_MAJOR = 2,
  parameter int REV_MINOR = 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_rd,
  input logic [11:0]        bus_addr,
  input logic [DATA_W-1:0]  bus_rdata,
  input logic               irq_out,
  input logic               idle_auto_en,
  input logic               ack_evt,
  input logic               srst_busy,
  input logic               pend_any,
  input logic [NUM_SRC-1:0] mask_flat
);
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out && !ack_evt && !srst_busy) |=> irq_out);

  assert_raise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_out && pend_any && !ack_evt && !srst_busy) |=> irq_out);

  assert_ack_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_evt |=> !irq_out);

  assert_srst_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
    srst_busy |=> (&mask_flat) && !irq_out);

  assert_srst_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(srst_busy) |-> !idle_auto_en);

  assert_rev_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 12'h000) |-> bus_rdata == DATA_W'({4'(REV_MAJOR), 4'(REV_MINOR)}));

  assert_rdgate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> bus_rdata == '0);
endmodule

bind lvl_irq_ctrl lvlirq_checker #(
  .NUM_SRC(NUM_SRC), .DATA_W(BANK_W), .REV_MAJOR(REV_MAJOR), .REV_MINOR(REV_MINOR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .irq_out(irq_out), .idle_auto_en(idle_auto_en),
  .ack_evt(ack_evt), .srst_busy(srst_busy), .pend_any(pend_any),
  .mask_flat(mask_flat)
);

// File: tb/lvl_irq_ctrl_tb_top.sv
module lvl_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [95:0] irq_src = '0;
  logic        irq_out, idle_auto_en;
  int n_vec = 0, n_bad = 0;

  always #5 clk = ~clk;

  lvl_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_src(irq_src), .irq_out(irq_out), .idle_auto_en(idle_auto_en)
  );

  function automatic logic [11:0] a_clr(int k);  return 12'h088 + 12'(k*32); endfunction
  function automatic logic [11:0] a_set(int k);  return 12'h08C + 12'(k*32); endfunction
  function automatic logic [11:0] a_pend(int k); return 12'h098 + 12'(k*32); endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 irq", 32'(irq_out), 0);
    chk("R1 autoidle", 32'(idle_auto_en), 0);
    rd(12'h014, d); chk("R1 done", d, 1);
    irq_src = '1;
    for (int k = 0; k < 3; k++) begin rd(a_pend(k), d); chk("R1 masked pend", d, 0); end
    cyc(1); chk("R1 no irq", 32'(irq_out), 0);
  endtask

  task automatic t_alias;
    logic [31:0] d;
    irq_src = '1;
    wr(a_clr(1), 32'h8000_0001);
    rd(a_pend(1), d); chk("R2 clr bank1", d, 32'h8000_0001);
    rd(a_pend(0), d); chk("R2 bank0 untouched", d, 0);
    rd(a_pend(2), d); chk("R2 bank2 untouched", d, 0);
    wr(a_clr(1), 32'h0000_0100);
    rd(a_pend(1), d); chk("R2 zeros keep", d, 32'h8000_0101);
    wr(a_set(1), 32'h8000_0000);
    rd(a_pend(1), d); chk("R3 set bit31", d, 32'h0000_0101);
    irq_src = 96'h0;
    irq_src[32+8] = 1'b1;
    rd(a_pend(1), d); chk("R4 pend follows src", d, 32'h0000_0100);
    for (int k = 0; k < 3; k++) wr(a_set(k), '1);
    wr(12'h048, 32'h1);
    cyc(1); chk("R6 cleared after mask", 32'(irq_out), 0);
    irq_src = '0;
  endtask

  task automatic t_latch_ack;
    wr(a_clr(2), 32'h8000_0000);
    cyc(1); chk("R5 idle low", 32'(irq_out), 0);
    irq_src[95] = 1'b1;
    cyc(1); chk("R5 raise src95", 32'(irq_out), 1);
    irq_src[95] = 1'b0;
    cyc(3); chk("R5 latched", 32'(irq_out), 1);
    wr(12'h048, 32'h0);
    cyc(1); chk("R6 bit0 zero ignored", 32'(irq_out), 1);
    wr(12'h048, 32'h1);
    chk("R6 ack drop", 32'(irq_out), 0);
    cyc(1); chk("R6 stays low", 32'(irq_out), 0);
  endtask

  task automatic t_level;
    irq_src[95] = 1'b1;
    cyc(1); chk("R7 raised", 32'(irq_out), 1);
    wr(12'h048, 32'h1);
    chk("R7 drop", 32'(irq_out), 0);
    cyc(1); chk("R7 re-raise", 32'(irq_out), 1);
    wr(a_set(2), 32'h8000_0000);
    wr(12'h048, 32'h1);
    cyc(1); chk("R7 masked stays low", 32'(irq_out), 0);
    irq_src = '0;
  endtask

  task automatic t_srst;
    logic [31:0] d;
    wr(12'h010, 32'h1);
    chk("R9 autoidle on", 32'(idle_auto_en), 1);
    rd(12'h010, d); chk("R9 cfg read", d, 1);
    wr(a_clr(0), 32'h0000_00FF);
    irq_src[0] = 1'b1;
    cyc(1); chk("R8 pre irq", 32'(irq_out), 1);
    wr(12'h010, 32'h2);
    rd(12'h014, d); chk("R8 busy c0", d, 0);
    chk("R8 autoidle cleared", 32'(idle_auto_en), 0);
    for (int i = 1; i < 4; i++) begin
      cyc(1); rd(12'h014, d); chk("R8 busy", d, 0);
    end
    cyc(1); rd(12'h014, d); chk("R8 done", d, 1);
    chk("R8 irq low", 32'(irq_out), 0);
    irq_src = '1;
    rd(a_pend(0), d); chk("R8 masks set", d, 0);
    irq_src = '0;
    wr(12'h010, 32'h0);
    chk("R9 autoidle off", 32'(idle_auto_en), 0);
  endtask

  task automatic t_reads;
    logic [31:0] d;
    rd(12'h000, d); chk("R10 revision", d, 32'h21);
    rd(12'h004, d); chk("R11 unmapped", d, 0);
    rd(12'h088, d); chk("R11 clr alias", d, 0);
    rd(12'h048, d); chk("R11 control", d, 0);
    bus_addr = 12'h000; #1;
    chk("R11 no strobe", bus_rdata, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    t_reset();
    t_alias();
    t_latch_ack();
    t_level();
    t_srst();
    t_reads();
    cyc(2);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule